// File: doc/BRIEF.md
# Host Bridge Control Register File

This block is the bank of 32-bit control and status words for a north-bridge style host bridge. Software reaches it over a simple word-addressed register bus: a write enable, a word index, 32 bits of write data and 32 bits of read data. Reads are combinational, so the addressed word appears on the read bus in the same cycle. The bank holds the power-on and general configuration words, IO device and SDRAM configuration, PCI mapping words, GPIO data and enable, interrupt-controller configuration (edge, steering, polarity), four mailboxes, PCI cache words, and timing, CPU, DQ and memory-size words.

The interrupt enable mask cannot be written directly. Software changes it through two alias words: bits written to the set alias are ORed into the mask, and bits written to the clear alias are removed from it. Each alias also keeps the last value written to it. The interrupt status word is read-only and is loaded from an input bus on every clock. Setting the CPU self-reset bit of the general configuration word from 0 to 1 makes a small state machine raise a one-cycle system reset request.

The reset-request machine has two states. RQ_IDLE is the resting state. The arm transition, RQ_IDLE to RQ_PULSE, is taken on a write that sets the self-reset bit while the stored bit is 0. RQ_PULSE drives the request for exactly one cycle, then takes the release transition back to RQ_IDLE unconditionally.

Top module: `hbctl_regs`

## Requirements
- R1: While rst_n is low, every word is loaded with its power-on value. Word 0 (power-on config) is 0x00000C40. Word 1 (general config) is 0x00001384, with bits 2, 7, 8, 9 and 12 set. Word 2 (IO device config) is 0x2BFF8010. Word 3 (SDRAM config) is 0x255E0091. Word 4 (PCI map) is 0x00006140. Words 7 and 8 (GPIO data and GPIO enable) are both 0x000001FF. Word 26 (DQ config) is 0x00000008. Word 27 (memory size) is 0x10000000. Every other word is 0, and sys_reset_req is 0.
- R2: Words 0 to 11 and 16 to 27 are plain storage. A write with reg_we high updates the indexed word at the clock edge. A read returns the stored word combinationally, and writing one word leaves the others unchanged.
- R3: A write to word 12 (set alias, byte offset 0x30) stores the data in word 12 and ORs it into word 14 (enable mask, byte offset 0x38).
- R4: A write to word 13 (clear alias, byte offset 0x34) stores the data in word 13 and clears the written bits in word 14.
- R5: Writes to word 14 (enable mask) and word 15 (interrupt status, byte offset 0x3C) have no effect on either word.
- R6: Word 15 takes the value of irq_stat_in at every clock edge, so a read returns the input as it was one cycle earlier.
- R7: A write to word 1 with bit 2 set, while the stored bit 2 is 0, updates word 1 and moves the machine from RQ_IDLE to RQ_PULSE. sys_reset_req is then high for exactly the one cycle after the write edge.
- R8: No reset request is raised when bit 2 of word 1 is written as 1 while it is already 1, when it is written as 0, or when bit 2 is set in any other word.
- R9: The window is 28 words (0x70 bytes). Reads at indexes 28 and above return 0, and writes to them change no word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the power-on values |
| reg_we | input | 1 | Write enable for the current bus cycle |
| reg_addr | input | ADDR_W (6) | Word index (byte offset shifted right by 2) |
| reg_wdata | input | 32 | Write data |
| irq_stat_in | input | 32 | Live interrupt status, captured every cycle into word 15 |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The enable mask is driven through a sequence of set-alias and clear-alias writes with overlapping, disjoint and top-bit patterns. This shows OR and AND-NOT accumulation apart from a plain overwrite, and it shows the value stored in each alias apart from the mask. Direct writes to the mask and the status word, and writes past the window, are followed by reads of the words they might have touched. The self-reset bit is written 1 to 0, 0 to 1, 1 to 1, and also set in an unrelated word, so a rising write is told apart from a level or a wrong decode. The status input is changed between edges to expose its one-cycle capture.

// File: rtl/hbctl_pkg.sv
package hbctl_pkg;

    localparam int DW     = 32;
    localparam int NWORDS = 28;

    // word indexes that carry behaviour or a non-zero power-on value
    localparam int IDX_PON     = 0;
    localparam int IDX_GEN     = 1;
    localparam int IDX_IODEV   = 2;
    localparam int IDX_SDRAM   = 3;
    localparam int IDX_PCIMAP  = 4;
    localparam int IDX_GPIODAT = 7;
    localparam int IDX_GPIOEN  = 8;
    localparam int IDX_ENSET   = 12;
    localparam int IDX_ENCLR   = 13;
    localparam int IDX_ENMASK  = 14;
    localparam int IDX_ISTAT   = 15;
    localparam int IDX_DQ      = 26;
    localparam int IDX_MEMSIZE = 27;

    // general configuration bit positions
    localparam int GEN_DEBUG    = 0;
    localparam int GEN_SNOOP    = 1;
    localparam int GEN_SELFRST  = 2;
    localparam int GEN_BSWAP    = 6;
    localparam int GEN_UNCACHED = 7;
    localparam int GEN_PREFETCH = 8;
    localparam int GEN_WBEHIND  = 9;
    localparam int GEN_PCIQ     = 12;

    typedef enum logic [2:0] {
        K_PLAIN,
        K_MASK,
        K_STAT
    } word_kind_e;

    typedef enum logic {
        RQ_IDLE,
        RQ_PULSE
    } rq_state_e;

    function automatic word_kind_e kind_of(input int idx);
        case (idx)
            IDX_ENMASK: return K_MASK;
            IDX_ISTAT:  return K_STAT;
            default:    return K_PLAIN;
        endcase
    endfunction

    function automatic logic [DW-1:0] default_of(input int idx);
        logic [DW-1:0] g;
        g = '0;
        g[GEN_SELFRST]  = 1'b1;
        g[GEN_UNCACHED] = 1'b1;
        g[GEN_PREFETCH] = 1'b1;
        g[GEN_WBEHIND]  = 1'b1;
        g[GEN_PCIQ]     = 1'b1;
        case (idx)
            IDX_PON:     return 32'h0000_0C40;
            IDX_GEN:     return g;
            IDX_IODEV:   return 32'h2BFF_8010;
            IDX_SDRAM:   return 32'h255E_0091;
            IDX_PCIMAP:  return 32'h0000_6140;
            IDX_GPIODAT: return 32'h0000_01FF;
            IDX_GPIOEN:  return 32'h0000_01FF;
            IDX_DQ:      return 32'h0000_0008;
            IDX_MEMSIZE: return 32'h1000_0000;
            default:     return '0;
        endcase
    endfunction

endpackage

// File: rtl/hbctl_decode.sv
module hbctl_decode
    import hbctl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int N      = NWORDS
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic [N-1:0]      wr_hit,
    output logic              in_win
);

    for (genvar i = 0; i < N; i++) begin : g_hit
        assign wr_hit[i] = we && (addr == ADDR_W'(i));
    end

    assign in_win = (addr < ADDR_W'(N));

endmodule

// File: rtl/hbctl_bank.sv
module hbctl_bank
    import hbctl_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int N      = NWORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      wr_hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] stat_in,
    output logic [DATA_W-1:0] words [N]
);

    for (genvar i = 0; i < N; i++) begin : g_word
        localparam word_kind_e  KIND = kind_of(i);
        localparam logic [DATA_W-1:0] INIT = DATA_W'(default_of(i));
        logic [DATA_W-1:0] q;

        if (KIND == K_MASK) begin : g_mask
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                   q <= INIT;
                else if (wr_hit[IDX_ENSET])   q <= q | wdata;
                else if (wr_hit[IDX_ENCLR])   q <= q & ~wdata;
            end

            assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
                wr_hit[IDX_ENSET] |=> (q == ($past(q) | $past(wdata))));
            assert_mask_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
                wr_hit[IDX_ENCLR] |=> (q == ($past(q) & ~$past(wdata))));
            assert_mask_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
                wr_hit[i] |=> $stable(q));
        end else if (KIND == K_STAT) begin : g_stat
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= INIT;
                else        q <= stat_in;
            end

            assert_stat_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
                wr_hit[i] |=> (q == $past(stat_in)));
            assert_stat_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (q == $past(stat_in)));
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         q <= INIT;
                else if (wr_hit[i]) q <= wdata;
            end
        end

        assign words[i] = q;
    end

endmodule

// File: rtl/hbctl_rstreq.sv
module hbctl_rstreq
    import hbctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic req
);

    rq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_IDLE:  state_d = arm ? RQ_PULSE : RQ_IDLE;
            RQ_PULSE: state_d = RQ_IDLE;
            default:  state_d = RQ_IDLE;
        endcase
    end

    always_comb begin
        req = (state_q == RQ_PULSE);
    end

    assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    assert_req_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && $past(rst_n)) |-> $past(arm));

endmodule

// File: rtl/hbctl_regs.sv
module hbctl_regs
    import hbctl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic [DW-1:0]     irq_stat_in,
    output logic [DW-1:0]     reg_rdata,
    output logic              sys_reset_req
);

    localparam int N = NWORDS;

    logic [N-1:0]  wr_hit;
    logic          in_win;
    logic [DW-1:0] words [N];
    logic [DW-1:0] sel;
    logic          arm;

    hbctl_decode #(.ADDR_W(ADDR_W), .N(N)) u_dec (
        .we     (reg_we),
        .addr   (reg_addr),
        .wr_hit (wr_hit),
        .in_win (in_win)
    );

    hbctl_bank #(.DATA_W(DW), .N(N)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wdata   (reg_wdata),
        .stat_in (irq_stat_in),
        .words   (words)
    );

    assign arm = wr_hit[IDX_GEN] && reg_wdata[GEN_SELFRST] && !words[IDX_GEN][GEN_SELFRST];

    hbctl_rstreq u_rq (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .req   (sys_reset_req)
    );

    always_comb begin
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (reg_addr == ADDR_W'(i)) sel = words[i];
        end
    end

    assign reg_rdata = in_win ? sel : '0;

    assert_arm_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(IDX_GEN) && reg_wdata[GEN_SELFRST]
         && !words[IDX_GEN][GEN_SELFRST]) |=> sys_reset_req);

    always_comb begin
        if (rst_n && !in_win) begin
            assert_oob_zero_R9: assert (reg_rdata == '0);
        end
    end

endmodule

// File: tb/hbctl_regs_test.sv
module hbctl_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] irq_stat_in = '0;
    logic [31:0] reg_rdata;
    logic        sys_reset_req;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    hbctl_regs uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .irq_stat_in   (irq_stat_in),
        .reg_rdata     (reg_rdata),
        .sys_reset_req (sys_reset_req)
    );

    // {req, write index, write data, read index, expected read}
    localparam int NV = 13;
    localparam logic [79:0] VEC [NV] = '{
        {4'd2, 6'd16, 32'hDEADBEEF, 6'd16, 32'hDEADBEEF},
        {4'd2, 6'd24, 32'hFFFFFFFF, 6'd24, 32'hFFFFFFFF},
        {4'd3, 6'd12, 32'h000000F0, 6'd14, 32'h000000F0},
        {4'd3, 6'd12, 32'h00000F00, 6'd12, 32'h00000F00},
        {4'd3, 6'd12, 32'h80000001, 6'd14, 32'h80000FF1},
        {4'd4, 6'd13, 32'h000000A0, 6'd14, 32'h80000F51},
        {4'd4, 6'd13, 32'h80000000, 6'd13, 32'h80000000},
        {4'd5, 6'd14, 32'hFFFFFFFF, 6'd14, 32'h00000F51},
        {4'd5, 6'd15, 32'h12345678, 6'd15, 32'h00000000},
        {4'd9, 6'd40, 32'h00000055, 6'd40, 32'h00000000},
        {4'd9, 6'd63, 32'h00000001, 6'd12, 32'h80000001},
        {4'd2, 6'd4,  32'h00000000, 6'd4,  32'h00000000},
        {4'd2, 6'd7,  32'h0000A5A5, 6'd8,  32'h000001FF}
    };

    function automatic logic [31:0] exp_reset(input int idx);
        case (idx)
            0:  return 32'h00000C40;
            1:  return 32'h00001384;
            2:  return 32'h2BFF8010;
            3:  return 32'h255E0091;
            4:  return 32'h00006140;
            7:  return 32'h000001FF;
            8:  return 32'h000001FF;
            26: return 32'h00000008;
            27: return 32'h10000000;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_up;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: power-on values of the whole window
        for (int i = 0; i < 28; i++) begin
            rd(6'(i), v);
            check($sformatf("R1 word %0d", i), v, exp_reset(i));
        end
        check("R1 request idle", {31'b0, sys_reset_req}, 32'h0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            wr(VEC[k][75:70], VEC[k][69:38]);
            rd(VEC[k][37:32], v);
            check($sformatf("R%0d vector %0d", int'(VEC[k][79:76]), k), v, VEC[k][31:0]);
        end
        rd(6'd0, v);
        check("R9 word 0 untouched", v, 32'h00000C40);

        // R6: status captured on the edge, not before it
        irq_stat_in = 32'hCAFE0001;
        rd(6'd15, v);
        check("R6 before edge", v, 32'h0);
        @(negedge clk);
        rd(6'd15, v);
        check("R6 after edge", v, 32'hCAFE0001);

        // R8: clearing bit 2 gives no pulse
        wr(6'd1, 32'h00001380);
        check("R8 clear no pulse", {31'b0, sys_reset_req}, 32'h0);
        rd(6'd1, v);
        check("R2 gen written", v, 32'h00001380);

        // R7: rising bit 2 gives one pulse
        wr(6'd1, 32'h00001384);
        check("R7 pulse high", {31'b0, sys_reset_req}, 32'h1);
        rd(6'd1, v);
        check("R7 gen updated", v, 32'h00001384);
        @(negedge clk);
        check("R7 pulse one cycle", {31'b0, sys_reset_req}, 32'h0);

        // R8: already set, and bit 2 in another word
        wr(6'd1, 32'h00001385);
        check("R8 already set", {31'b0, sys_reset_req}, 32'h0);
        wr(6'd0, 32'h00000004);
        check("R8 other word", {31'b0, sys_reset_req}, 32'h0);

        finish_up();
    end

endmodule